// File: doc/BRIEF.md
# Single-Entry Posted Write Buffer

This block sits inside a bus controller between one internal bus requester and a slow external memory bus. It is shared in time by the CPU and a DMA controller, and the external arbiter reports which of them owns the internal bus through a single grant input. A write to external space is latched into a one-entry buffer and acknowledged at once. The requester can then carry on while the external cycle drains in the background. Accesses to on-chip peripherals are served in the same cycle, even while an external write is still outstanding.

Ordering is enforced only where it matters. An external read is not launched until the buffered write has fully drained. A read to the address just written therefore returns the new data, and its return tells the requester that the write has landed. A DMA transfer whose source and destination are both external gets the same ordering, because each of its source reads waits for the previous destination write. A second external write that finds the entry occupied waits until the entry empties. The length of each external cycle is set by a wait-state count, and the end of each cycle is marked by a one-cycle done pulse.

A requester holds `req_valid` and its payload stable until it sees `req_ack`. `req_ack` is a combinational response in the cycle the access completes.

Top module: `posted_write_buffer`

## Requirements
- R1: The buffer holds at most one external write. An external write request that finds the entry full gets no acknowledge until the cycle after the drain's `ext_done`. The entry stays occupied until the external write cycle signals done.
- R2: An external write that finds the entry empty while `bus_grant` is high is acknowledged in the same cycle it is presented. The acknowledge does not wait for the external cycle.
- R3: While `bus_grant` is low, no write and no peripheral access is acknowledged. The acknowledge appears in the first cycle the grant is high and the other conditions hold.
- R4: A peripheral access (`req_periph`=1) is acknowledged in the same cycle whenever `bus_grant` is high, even if an external write is pending. It drives `per_sel`, `per_write`, `per_addr` and `per_wdata`, and a read returns `per_rdata` on `req_rdata`.
- R5: An external read is launched only while the entry is empty, the external bus is idle and `bus_grant` is high. A read of a just-written address returns the written data.
- R6: An external cycle keeps `ext_cyc` high for `ext_wait_states`+1 cycles. `ext_done` is a one-cycle pulse on the last of those cycles. An external read is acknowledged in that cycle, with `req_rdata` equal to `ext_rdata`, whether or not the grant is still held.
- R7: A buffered write starts on the external bus after one idle cycle. `ext_cyc` rises in the second cycle after the acknowledge, with `ext_we`=1 and the buffered address and data held stable to the end of the cycle.
- R8: After reset, `req_ack`, `ext_cyc`, `ext_done` and `per_sel` are low, and the entry is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_grant | input | 1 | Requester currently owns the internal bus |
| req_valid | input | 1 | Access request, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_periph | input | 1 | 1 = on-chip peripheral space, 0 = external space |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_ack | output | 1 | Access complete in this cycle |
| req_rdata | output | DW | Read data, valid with `req_ack` on reads |
| per_sel | output | 1 | Peripheral access strobe |
| per_write | output | 1 | Peripheral write enable |
| per_addr | output | AW | Peripheral address |
| per_wdata | output | DW | Peripheral write data |
| per_rdata | input | DW | Peripheral read data, combinational |
| ext_wait_states | input | WSW | Extra cycles per external access |
| ext_cyc | output | 1 | External cycle in progress |
| ext_we | output | 1 | External cycle is a write |
| ext_addr | output | AW | External address |
| ext_wdata | output | DW | External write data |
| ext_rdata | input | DW | External read data, sampled on `ext_done` |
| ext_done | output | 1 | Last cycle of an external access |

## Verification
Some properties can be checked on every cycle. Writes and peripheral accesses never complete without the grant. A write is never accepted into a full entry, and the entry never empties without a write done. No external read runs while the entry is occupied. The done pulse is single and falls inside an external cycle, and the address stays put for the whole cycle. Other behaviour can only be shown by the bench's scenarios. These are the exact stall lengths behind a draining write, the idle cycle before a drain begins, the length of the external cycle for different wait-state counts, and the data a same-address read returns after a posted write.

// File: rtl/pwb_pkg.sv
// Package: shared types for the posted write buffer.
// Assumes: nothing beyond standard SystemVerilog.
package pwb_pkg;

    // Kind of access the external engine is performing.
    typedef enum logic {
        EXT_RD = 1'b0,
        EXT_WR = 1'b1
    } ext_op_e;

endpackage

// File: rtl/pwb_entry.sv
// Module: pwb_entry
// Holds the single pending external write (address, data, occupied flag).
// Assumes: load is never asserted while full, so load and drain_done never coincide.
module pwb_entry #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  logic          drain_done,
    output logic          full,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);

    // Occupied flag: set on load, cleared when the external write finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            full <= 1'b0;
        else if (load)
            full <= 1'b1;
        else if (drain_done)
            full <= 1'b0;
    end

    // Payload capture on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (load) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end

endmodule

// File: rtl/pwb_ext_engine.sv
// Module: pwb_ext_engine
// Runs one external access at a time for wait_states+1 cycles, flagging the last cycle.
// Assumes: launch is only honoured while idle; wait_states is sampled at launch.
module pwb_ext_engine
    import pwb_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int WSW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           launch,
    input  ext_op_e        op_in,
    input  logic [AW-1:0]  addr_in,
    input  logic [DW-1:0]  data_in,
    input  logic [WSW-1:0] wait_states,
    output logic           busy,
    output ext_op_e        op_q,
    output logic [AW-1:0]  addr_q,
    output logic [DW-1:0]  data_q,
    output logic           done
);

    logic [WSW-1:0] cnt_q;

    // Cycle sequencer: start on launch, count down, go idle after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (!busy) begin
            if (launch) begin
                busy  <= 1'b1;
                cnt_q <= wait_states;
            end
        end else if (cnt_q == '0) begin
            busy <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Access attributes latched at launch and held for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= EXT_RD;
            addr_q <= '0;
            data_q <= '0;
        end else if (!busy && launch) begin
            op_q   <= op_in;
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end

    // Last cycle of the access.
    always_comb done = busy && (cnt_q == '0);

endmodule

// File: rtl/pwb_order.sv
// Module: pwb_order
// Decides acknowledges, buffer loads and external launches from region, grant and buffer state.
// Assumes: one requester at a time holding its request until acknowledged.
module pwb_order
    import pwb_pkg::*;
(
    input  logic    req_valid,
    input  logic    req_write,
    input  logic    req_periph,
    input  logic    bus_grant,
    input  logic    full,
    input  logic    eng_busy,
    input  logic    eng_done,
    input  ext_op_e eng_op,
    output logic    per_go,
    output logic    wr_load,
    output logic    launch,
    output ext_op_e launch_op,
    output logic    ack
);

    logic ext_rd_req, ext_wr_req, drain_go, rd_go, rd_ack;

    // Request classification and ordering rules.
    always_comb begin
        ext_rd_req = req_valid && !req_periph && !req_write;
        ext_wr_req = req_valid && !req_periph && req_write;
        per_go     = req_valid && req_periph && bus_grant;
        wr_load    = ext_wr_req && bus_grant && !full;
        drain_go   = full && !eng_busy;
        rd_go      = ext_rd_req && bus_grant && !full && !eng_busy;
        launch     = drain_go || rd_go;
        launch_op  = drain_go ? EXT_WR : EXT_RD;
        rd_ack     = ext_rd_req && eng_done && (eng_op == EXT_RD);
        ack        = per_go || wr_load || rd_ack;
    end

endmodule

// File: rtl/posted_write_buffer.sv
// Module: posted_write_buffer (top)
// One-entry posted write buffer with region-aware ordering between an internal
// bus requester, on-chip peripherals and a wait-stated external bus.
// Assumes: per_rdata is combinational; requester holds its payload until req_ack.
module posted_write_buffer
    import pwb_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int WSW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_grant,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic           req_periph,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    output logic           req_ack,
    output logic [DW-1:0]  req_rdata,
    output logic           per_sel,
    output logic           per_write,
    output logic [AW-1:0]  per_addr,
    output logic [DW-1:0]  per_wdata,
    input  logic [DW-1:0]  per_rdata,
    input  logic [WSW-1:0] ext_wait_states,
    output logic           ext_cyc,
    output logic           ext_we,
    output logic [AW-1:0]  ext_addr,
    output logic [DW-1:0]  ext_wdata,
    input  logic [DW-1:0]  ext_rdata,
    output logic           ext_done
);

    logic          entry_full;
    logic [AW-1:0] entry_addr;
    logic [DW-1:0] entry_data;
    logic          eng_busy, eng_done, per_go, wr_load, launch;
    ext_op_e       eng_op, launch_op;
    logic [AW-1:0] launch_addr;
    logic [DW-1:0] launch_data;

    pwb_order u_order (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_periph(req_periph),
        .bus_grant (bus_grant),
        .full      (entry_full),
        .eng_busy  (eng_busy),
        .eng_done  (eng_done),
        .eng_op    (eng_op),
        .per_go    (per_go),
        .wr_load   (wr_load),
        .launch    (launch),
        .launch_op (launch_op),
        .ack       (req_ack)
    );

    pwb_entry #(.AW(AW), .DW(DW)) u_entry (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_load),
        .addr_in   (req_addr),
        .data_in   (req_wdata),
        .drain_done(eng_done && (eng_op == EXT_WR)),
        .full      (entry_full),
        .addr_q    (entry_addr),
        .data_q    (entry_data)
    );

    // Launch source: the buffered write when draining, else the live read request.
    always_comb begin
        launch_addr = (launch_op == EXT_WR) ? entry_addr : req_addr;
        launch_data = entry_data;
    end

    pwb_ext_engine #(.AW(AW), .DW(DW), .WSW(WSW)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .op_in      (launch_op),
        .addr_in    (launch_addr),
        .data_in    (launch_data),
        .wait_states(ext_wait_states),
        .busy       (eng_busy),
        .op_q       (eng_op),
        .addr_q     (ext_addr),
        .data_q     (ext_wdata),
        .done       (eng_done)
    );

    // Port wiring for the peripheral path, the external bus and read data return.
    always_comb begin
        per_sel   = per_go;
        per_write = req_write;
        per_addr  = req_addr;
        per_wdata = req_wdata;
        ext_cyc   = eng_busy;
        ext_we    = (eng_op == EXT_WR);
        ext_done  = eng_done;
        req_rdata = req_periph ? per_rdata : ext_rdata;
    end

endmodule

// File: rtl/pwb_checker.sv
// Module: pwb_checker
// Cycle-level properties of the posted write buffer, bound onto the top module.
// Assumes: synchronous active-low reset; entry_full is the buffer's occupied flag.
module pwb_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_grant,
    input logic          req_valid,
    input logic          req_write,
    input logic          req_periph,
    input logic          req_ack,
    input logic          per_sel,
    input logic          ext_cyc,
    input logic          ext_we,
    input logic [AW-1:0] ext_addr,
    input logic          ext_done,
    input logic          entry_full
);

    // R3
    grant_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack && (req_write || req_periph) |-> bus_grant);

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack && req_write && !req_periph |-> !entry_full);

    // R1
    entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_full && !(ext_done && ext_we) |=> entry_full);

    // R5
    read_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cyc && !ext_we |-> !entry_full);

    // R6
    done_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_done |-> ext_cyc);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_done |=> !ext_done);

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cyc && !ext_done |=> ext_cyc && $stable(ext_addr) && $stable(ext_we));

    // R4
    periph_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_periph && bus_grant |-> req_ack && per_sel);

endmodule

bind posted_write_buffer pwb_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_grant (bus_grant),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_periph(req_periph),
    .req_ack   (req_ack),
    .per_sel   (per_sel),
    .ext_cyc   (ext_cyc),
    .ext_we    (ext_we),
    .ext_addr  (ext_addr),
    .ext_done  (ext_done),
    .entry_full(entry_full)
);

// File: tb/posted_write_buffer_tb.sv
// Bench for posted_write_buffer: a vector table walked by one loop, then directed cases.
module posted_write_buffer_tb;

    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int WSW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_grant = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_write = 1'b0;
    logic           req_periph = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic           req_ack;
    logic [DW-1:0]  req_rdata;
    logic           per_sel, per_write;
    logic [AW-1:0]  per_addr;
    logic [DW-1:0]  per_wdata, per_rdata;
    logic [WSW-1:0] ext_wait_states = 4'd2;
    logic           ext_cyc, ext_we, ext_done;
    logic [AW-1:0]  ext_addr;
    logic [DW-1:0]  ext_wdata, ext_rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    posted_write_buffer #(.AW(AW), .DW(DW), .WSW(WSW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant),
        .req_valid(req_valid), .req_write(req_write), .req_periph(req_periph),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack), .req_rdata(req_rdata),
        .per_sel(per_sel), .per_write(per_write), .per_addr(per_addr),
        .per_wdata(per_wdata), .per_rdata(per_rdata),
        .ext_wait_states(ext_wait_states), .ext_cyc(ext_cyc), .ext_we(ext_we),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_done(ext_done)
    );

    // Memory models: external memory updates at the end of a write cycle.
    logic [DW-1:0] emem [16];
    logic [DW-1:0] pmem [16];
    initial for (int i = 0; i < 16; i++) begin emem[i] = '0; pmem[i] = '0; end
    always @(posedge clk) begin
        if (ext_done && ext_we) emem[ext_addr[3:0]] <= ext_wdata;
        if (per_sel && per_write) pmem[per_addr[3:0]] <= per_wdata;
    end
    assign ext_rdata = emem[ext_addr[3:0]];
    assign per_rdata = pmem[per_addr[3:0]];

    typedef struct packed {
        logic          wr;
        logic          per;
        logic [3:0]    gdly;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [7:0]    lat;
        logic [3:0]    rq;
    } vec_t;

    // Wait states = 2, each access presented the cycle after the previous acknowledge.
    localparam vec_t VECS [11] = '{
        '{1'b1, 1'b0, 4'd0, 16'h1004, 32'hA0A0_0001, 8'd0, 4'd2}, // R2 post to empty entry
        '{1'b1, 1'b1, 4'd0, 16'h0006, 32'h5EE0_0006, 8'd0, 4'd4}, // R4 periph write, drain pending
        '{1'b0, 1'b1, 4'd0, 16'h0006, 32'h5EE0_0006, 8'd0, 4'd4}, // R4 periph read-back
        '{1'b1, 1'b0, 4'd0, 16'h2008, 32'hB0B0_0002, 8'd2, 4'd1}, // R1 stall on full entry
        '{1'b0, 1'b0, 4'd0, 16'h2008, 32'hB0B0_0002, 8'd7, 4'd5}, // R5 same-address read
        '{1'b0, 1'b0, 4'd0, 16'h1004, 32'hA0A0_0001, 8'd3, 4'd6}, // R6 idle read
        '{1'b1, 1'b0, 4'd3, 16'h300C, 32'hC0C0_0003, 8'd3, 4'd3}, // R3 write waits for grant
        '{1'b1, 1'b1, 4'd2, 16'h0007, 32'h5EE0_0007, 8'd2, 4'd3}, // R3 periph waits for grant
        '{1'b1, 1'b0, 4'd0, 16'h4002, 32'hD0D0_0004, 8'd1, 4'd1}, // R1 released after done
        '{1'b0, 1'b0, 4'd0, 16'h300C, 32'hC0C0_0003, 8'd7, 4'd5}, // R5 read behind drain
        '{1'b0, 1'b0, 4'd0, 16'h4002, 32'hD0D0_0004, 8'd3, 4'd5}  // R5 second written word
    };

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one access; grant is withheld for gdly cycles; returns cycles to acknowledge.
    task automatic run_op(input logic wr, input logic per, input int gdly,
                          input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output int lat, output logic [DW-1:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_periph = per; req_addr = a; req_wdata = d;
        lat = 0;
        forever begin
            bus_grant = (lat >= gdly);
            #1;
            if (req_ack || lat > 100) break;
            @(negedge clk);
            lat++;
        end
        rd = req_rdata;
    endtask

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        logic [DW-1:0] rd;
        repeat (3) @(negedge clk);
        // R8 outputs quiet in reset
        check(!req_ack && !ext_cyc && !ext_done && !per_sel, "R8", {ext_cyc, ext_done}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(!ext_cyc && !ext_done, "R8", ext_cyc, 0);

        foreach (VECS[i]) begin
            run_op(VECS[i].wr, VECS[i].per, int'(VECS[i].gdly), VECS[i].addr,
                   VECS[i].data, lat, rd);
            check(lat == int'(VECS[i].lat), $sformatf("R%0d latency v%0d", VECS[i].rq, i),
                  lat, VECS[i].lat);
            if (!VECS[i].wr)
                check(rd == VECS[i].data, $sformatf("R%0d data v%0d", VECS[i].rq, i),
                      rd, VECS[i].data);
        end

        // R7 drain timing and held attributes
        run_op(1'b1, 1'b0, 0, 16'h500A, 32'hE0E0_0005, lat, rd);
        check(lat == 0, "R2", lat, 0);
        @(negedge clk); req_valid = 1'b0; #1;
        check(!ext_cyc, "R7 idle cycle", ext_cyc, 0);
        @(negedge clk); #1;
        check(ext_cyc && ext_we && ext_addr == 16'h500A && ext_wdata == 32'hE0E0_0005,
              "R7 drain start", ext_wdata, 32'hE0E0_0005);
        @(negedge clk); #1;
        check(ext_cyc && !ext_done, "R6 mid cycle", ext_done, 0);
        @(negedge clk); #1;
        check(ext_cyc && ext_done, "R6 last cycle", ext_done, 1);
        @(negedge clk); #1;
        check(!ext_cyc && !ext_done, "R6 cycle end", ext_cyc, 0);

        // R6 wait-state count zero and five
        ext_wait_states = 4'd0;
        run_op(1'b0, 1'b0, 0, 16'h500A, 32'h0, lat, rd);
        check(lat == 1, "R6 zero waits", lat, 1);
        check(rd == 32'hE0E0_0005, "R5 data", rd, 32'hE0E0_0005);
        ext_wait_states = 4'd5;
        run_op(1'b0, 1'b0, 0, 16'h1004, 32'h0, lat, rd);
        check(lat == 6, "R6 five waits", lat, 6);
        // R5 read waits for grant before launching
        run_op(1'b0, 1'b0, 2, 16'h2008, 32'h0, lat, rd);
        check(lat == 8, "R5 grant gate", lat, 8);
        check(rd == 32'hB0B0_0002, "R5 data", rd, 32'hB0B0_0002);
        @(negedge clk); req_valid = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule